// File: doc/BRIEF.md
# Interrupt Service State Tracker

This block follows a bank of peripheral interrupt lines through their service lifecycle on behalf of up to four CPUs. Each line owns a fixed interrupt ID, `BASE_ID + index`, and sits in one of four states: idle, waiting, in service, or in service and waiting again. A rising edge on a line raises a request. A CPU claims the lowest-numbered waiting interrupt with an acknowledge strobe, and the block replies with that interrupt's ID. The claiming CPU later retires the interrupt by writing its ID on the completion port.

The tracker records which CPU claimed each interrupt. A completion write from any other CPU is discarded. When a completion and an acknowledge arrive in the same cycle, the completion is applied first, so an interrupt it returns to the waiting state can be claimed by that same acknowledge. Priority masking, grouping and routing to particular CPUs are left to the surrounding logic.

Top module: `irq_life_tracker`

## Requirements
- R1: After reset every interrupt reads state 2'b00 (idle), `pend_any` is 0 and `ack_id` holds the spurious value 1023.
- R2: A rising edge on `irq_in[i]` moves interrupt i from idle (2'b00) to waiting (2'b01), visible on `state_out[2i+1:2i]` after the clock edge that samples the rise. A line held high raises no further requests.
- R3: An acknowledge with at least one interrupt waiting claims the lowest-indexed waiting interrupt. That interrupt moves to in-service (2'b10), and `ack_id` shows `BASE_ID + index` after the same clock edge.
- R4: An acknowledge with no interrupt waiting sets `ack_id` to 1023. Without an acknowledge, `ack_id` keeps its value.
- R5: A completion write that carries the interrupt's ID and the CPU number that claimed it moves an in-service interrupt to idle.
- R6: A rising edge while an interrupt is in service moves it to in-service-and-waiting (2'b11). A valid completion in that state moves it to waiting.
- R7: A completion write is ignored, and every state stays unchanged, if its CPU number differs from the claiming CPU, if its ID matches no interrupt, or if the named interrupt is not in service.
- R8: When a completion and an acknowledge occur in the same cycle, the completion is applied first, and the acknowledge then chooses among the interrupts waiting after it.
- R9: `pend_any` is 1 exactly when at least one interrupt is in the waiting state 2'b01.
- R10: A rising edge on an interrupt that is already waiting, or already in service and waiting, leaves its state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_IRQ | Interrupt lines, edge-sensitive |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_cpu | input | CPU_W | CPU issuing the acknowledge |
| ack_id | output | ID_W | Registered ID of the claimed interrupt, or 1023 |
| eoi_valid | input | 1 | Completion write strobe |
| eoi_cpu | input | CPU_W | CPU issuing the completion |
| eoi_id | input | ID_W | Interrupt ID being completed |
| state_out | output | 2*NUM_IRQ | Per-interrupt state, two bits per interrupt |
| pend_any | output | 1 | Registered flag: some interrupt is waiting |

## Verification
The bench builds the block with six interrupt lines, four CPUs and a base ID of 32. With six lines, every slot can be pushed through all four states within a short run. The lowest-index selection also meets collisions often, both among the low slots and at the top slot. Four CPUs give a two-bit CPU field, so a random completion often comes from a CPU other than the claimer. Completion IDs are drawn from one below the base to one past the last slot, so writes that match no interrupt are also exercised.

// File: rtl/irq_life_pkg.sv
package irq_life_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'b00,
    ST_PEND   = 2'b01,
    ST_ACT    = 2'b10,
    ST_ACTPND = 2'b11
  } irq_st_e;

  localparam int SPURIOUS_ID = 1023;
endpackage

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] lvl,
  output logic [WIDTH-1:0] rise
);
  logic [WIDTH-1:0] lvl_q;

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= '0;
    else     lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q;
endmodule

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
  parameter int WIDTH = 8,
  parameter int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic [WIDTH-1:0] req,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int k = WIDTH - 1; k >= 0; k--) begin
      if (req[k]) begin
        found = 1'b1;
        idx   = IDX_W'(k);
      end
    end
  end
endmodule

// File: rtl/irq_slot.sv
module irq_slot
  import irq_life_pkg::*;
#(
  parameter int CPU_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rise,
  input  logic             eoi_hit,
  input  logic [CPU_W-1:0] eoi_cpu,
  input  logic             grant,
  input  logic [CPU_W-1:0] ack_cpu,
  output logic             pend_mid,
  output logic             pend_nxt,
  output logic [1:0]       st_o
);
  irq_st_e          st_q, mid, aft, nxt;
  logic [CPU_W-1:0] own_q;

  always_comb begin
    // completion is evaluated before the acknowledge
    mid = st_q;
    if (eoi_hit && own_q == eoi_cpu) begin
      case (st_q)
        ST_ACT:    mid = ST_IDLE;
        ST_ACTPND: mid = ST_PEND;
        default:   mid = st_q;
      endcase
    end
    aft = (grant && mid == ST_PEND) ? ST_ACT : mid;
    nxt = aft;
    if (rise) begin
      case (aft)
        ST_IDLE: nxt = ST_PEND;
        ST_ACT:  nxt = ST_ACTPND;
        default: nxt = aft;
      endcase
    end
  end

  assign pend_mid = (mid == ST_PEND);
  assign pend_nxt = (nxt == ST_PEND);
  assign st_o     = st_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      own_q <= '0;
    end else begin
      st_q <= nxt;
      if (grant && mid == ST_PEND) own_q <= ack_cpu;
    end
  end
endmodule

// File: rtl/irq_life_tracker.sv
module irq_life_tracker
  import irq_life_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  parameter int NUM_CPU = 4,
  parameter int CPU_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  parameter int ID_W    = 10,
  parameter int BASE_ID = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_IRQ-1:0]   irq_in,
  input  logic                 ack_valid,
  input  logic [CPU_W-1:0]     ack_cpu,
  output logic [ID_W-1:0]      ack_id,
  input  logic                 eoi_valid,
  input  logic [CPU_W-1:0]     eoi_cpu,
  input  logic [ID_W-1:0]      eoi_id,
  output logic [2*NUM_IRQ-1:0] state_out,
  output logic                 pend_any
);
  localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

  logic [NUM_IRQ-1:0] rise, pend_mid, pend_nxt, grant;
  logic               found;
  logic [IDX_W-1:0]   pick;

  irq_edge_detect #(.WIDTH(NUM_IRQ)) u_edge (
    .clk (clk),
    .rst (rst),
    .lvl (irq_in),
    .rise(rise)
  );

  irq_lowest_pick #(.WIDTH(NUM_IRQ), .IDX_W(IDX_W)) u_pick (
    .req  (pend_mid),
    .found(found),
    .idx  (pick)
  );

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_slot
    logic eoi_hit;
    assign eoi_hit  = eoi_valid && (eoi_id == ID_W'(BASE_ID + i));
    assign grant[i] = ack_valid && found && (pick == IDX_W'(i));

    irq_slot #(.CPU_W(CPU_W)) u_slot (
      .clk     (clk),
      .rst     (rst),
      .rise    (rise[i]),
      .eoi_hit (eoi_hit),
      .eoi_cpu (eoi_cpu),
      .grant   (grant[i]),
      .ack_cpu (ack_cpu),
      .pend_mid(pend_mid[i]),
      .pend_nxt(pend_nxt[i]),
      .st_o    (state_out[2*i +: 2])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_id   <= ID_W'(SPURIOUS_ID);
      pend_any <= 1'b0;
    end else begin
      if (ack_valid)
        ack_id <= found ? ID_W'(BASE_ID) + ID_W'(pick) : ID_W'(SPURIOUS_ID);
      pend_any <= |pend_nxt;
    end
  end
endmodule

// File: rtl/irq_life_chk.sv
module irq_life_chk
  import irq_life_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  parameter int ID_W    = 10,
  parameter int BASE_ID = 32
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 ack_valid,
  input logic [ID_W-1:0]      ack_id,
  input logic [2*NUM_IRQ-1:0] state_out,
  input logic                 pend_any
);
  logic any_wait;
  always_comb begin
    any_wait = 1'b0;
    for (int k = 0; k < NUM_IRQ; k++)
      if (state_out[2*k +: 2] == 2'b01) any_wait = 1'b1;
  end

  // R9
  pend_any_match_chk: assert property (@(posedge clk) disable iff (rst)
    pend_any == any_wait);

  // R4
  ack_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ack_valid |=> $stable(ack_id));

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_chk
    // R2
    idle_step_chk: assert property (@(posedge clk) disable iff (rst)
      state_out[2*i +: 2] == 2'b00 |=> state_out[2*i +: 2] inside {2'b00, 2'b01});

    // R3
    claimed_active_chk: assert property (@(posedge clk) disable iff (rst)
      ack_valid |=> (ack_id == ID_W'(BASE_ID + i)) -> state_out[2*i + 1]);
  end
endmodule

bind irq_life_tracker irq_life_chk #(
  .NUM_IRQ(NUM_IRQ),
  .ID_W   (ID_W),
  .BASE_ID(BASE_ID)
) u_life_chk (
  .clk      (clk),
  .rst      (rst),
  .ack_valid(ack_valid),
  .ack_id   (ack_id),
  .state_out(state_out),
  .pend_any (pend_any)
);

// File: tb/test_irq_life_tracker.sv
module test_irq_life_tracker;
  localparam int N    = 6;
  localparam int NCPU = 4;
  localparam int CW   = 2;
  localparam int IW   = 10;
  localparam int BASE = 32;

  logic          clk = 0;
  logic          rst = 1;
  logic [N-1:0]  irq_in = '0;
  logic          ack_valid = 0;
  logic [CW-1:0] ack_cpu = '0;
  logic [IW-1:0] ack_id;
  logic          eoi_valid = 0;
  logic [CW-1:0] eoi_cpu = '0;
  logic [IW-1:0] eoi_id = '0;
  logic [2*N-1:0] state_out;
  logic          pend_any;

  int errors = 0;
  int checks = 0;

  // behavioural reference
  int m_st[N];
  int m_own[N];
  bit m_prev[N];
  int m_ack;
  bit m_pany;

  always #2 clk = ~clk;

  irq_life_tracker #(.NUM_IRQ(N), .NUM_CPU(NCPU), .CPU_W(CW), .ID_W(IW), .BASE_ID(BASE))
    i_irq_life_tracker (
      .clk(clk), .rst(rst), .irq_in(irq_in), .ack_valid(ack_valid), .ack_cpu(ack_cpu),
      .ack_id(ack_id), .eoi_valid(eoi_valid), .eoi_cpu(eoi_cpu), .eoi_id(eoi_id),
      .state_out(state_out), .pend_any(pend_any));

  always @(posedge clk) begin
    if (rst) begin
      foreach (m_st[i]) begin m_st[i] = 0; m_own[i] = 0; m_prev[i] = 0; end
      m_ack = 1023; m_pany = 0;
    end else begin
      int sel;
      for (int i = 0; i < N; i++)
        if (eoi_valid && int'(eoi_id) == BASE + i && m_own[i] == int'(eoi_cpu)) begin
          if (m_st[i] == 2) m_st[i] = 0;
          else if (m_st[i] == 3) m_st[i] = 1;
        end
      sel = -1;
      for (int i = N - 1; i >= 0; i--) if (m_st[i] == 1) sel = i;
      if (ack_valid) begin
        if (sel >= 0) begin
          m_st[sel] = 2; m_own[sel] = int'(ack_cpu); m_ack = BASE + sel;
        end else m_ack = 1023;
      end
      for (int i = 0; i < N; i++) begin
        if (irq_in[i] && !m_prev[i]) begin
          if (m_st[i] == 0) m_st[i] = 1;
          else if (m_st[i] == 2) m_st[i] = 3;
        end
        m_prev[i] = irq_in[i];
      end
      m_pany = 0;
      foreach (m_st[i]) if (m_st[i] == 1) m_pany = 1;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int st(input int i);
    return int'(state_out[2*i +: 2]);
  endfunction

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (!rst) begin
      for (int i = 0; i < N; i++) chk("R6 state vs model", st(i), m_st[i]);
      chk("R9 pend_any vs model", int'(pend_any), int'(m_pany));
      chk("R3 ack_id vs model", int'(ack_id), m_ack);
    end
  end

  task automatic cyc();
    @(negedge clk);
    ack_valid = 0;
    eoi_valid = 0;
  endtask

  task automatic ack(input int cpu);
    ack_valid = 1; ack_cpu = CW'(cpu);
  endtask

  task automatic eoi(input int cpu, input int id);
    eoi_valid = 1; eoi_cpu = CW'(cpu); eoi_id = IW'(id);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1
    for (int i = 0; i < N; i++) chk("R1 reset state", st(i), 0);
    chk("R1 reset pend_any", int'(pend_any), 0);
    chk("R1 reset ack_id", int'(ack_id), 1023);

    ack(0); cyc();
    chk("R4 spurious reply", int'(ack_id), 1023);
    cyc();
    chk("R4 reply held", int'(ack_id), 1023);

    irq_in[3] = 1; irq_in[1] = 1; cyc();
    chk("R2 irq1 waiting", st(1), 1);
    chk("R2 irq3 waiting", st(3), 1);
    chk("R9 pend_any set", int'(pend_any), 1);

    ack(2); cyc();
    chk("R3 lowest claimed", int'(ack_id), BASE + 1);
    chk("R3 irq1 active", st(1), 2);
    cyc();
    chk("R2 level no retrigger", st(1), 2);

    eoi(1, BASE + 1); cyc();
    chk("R7 wrong cpu ignored", st(1), 2);
    eoi(2, BASE + 40); cyc();
    chk("R7 unknown id ignored", st(1), 2);
    eoi(2, BASE + 3); cyc();
    chk("R7 not in service ignored", st(3), 1);

    irq_in[1] = 0; cyc();
    irq_in[1] = 1; cyc();
    chk("R6 active then waiting", st(1), 3);
    irq_in[1] = 0; cyc();
    irq_in[1] = 1; cyc();
    chk("R10 second edge absorbed", st(1), 3);
    irq_in[3] = 0; cyc();
    irq_in[3] = 1; cyc();
    chk("R10 edge on waiting", st(3), 1);

    eoi(2, BASE + 1); ack(0); cyc();
    chk("R8 eoi first then claim", int'(ack_id), BASE + 1);
    chk("R8 irq1 in service", st(1), 2);

    eoi(2, BASE + 1); cyc();
    chk("R7 old owner ignored", st(1), 2);
    eoi(0, BASE + 1); cyc();
    chk("R5 completion to idle", st(1), 0);

    ack(3); cyc();
    chk("R3 next claim", int'(ack_id), BASE + 3);
    chk("R9 pend_any clear", int'(pend_any), 0);
    ack(1); cyc();
    chk("R4 none waiting", int'(ack_id), 1023);

    eoi(3, BASE + 3); irq_in[3] = 0; cyc();
    chk("R5 irq3 idle", st(3), 0);

    // random phase
    for (int n = 0; n < 2000; n++) begin
      irq_in = irq_in ^ N'($urandom_range(0, (1 << N) - 1) & $urandom_range(0, (1 << N) - 1));
      if ($urandom_range(0, 1) == 1) ack(int'($urandom_range(0, NCPU - 1)));
      if ($urandom_range(0, 1) == 1)
        eoi(int'($urandom_range(0, NCPU - 1)), int'($urandom_range(BASE - 1, BASE + N)));
      cyc();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule